// File: doc/BRIEF.md
# Start-Triggered Counting Sequencer

This block is a small controller paired with its datapath. It idles until a start request arrives. It then clears a four-bit count and a completion flag, and counts up by one on every clock. On each step it copies one chosen count bit, as it stood before the step, into a status flip-flop. When two chosen count bits are both high, it finishes. The finishing cycle raises the completion flag, and the block then drops back to idle. Three indicator outputs show which phase the controller is in. They are decoded from a two-bit binary state register: idle is 00, counting is 01 and finished is 11.

A state's register transfers and its state change take effect on the same clock edge. Every decision reads register values from before that edge. Started from zero with the default bit choices, the block counts through 0..6 and leaves the counting phase on the edge where the count is 6. It ends with count 7, status 1 and completion 1. Synchronous reset affects only the controller, which it forces to idle. The count and both flags keep their values through reset, and only a later start request clears them.

Top module: `asm_count_ctl`

## Requirements
- R1: While `rst` is high at a rising edge, the controller enters idle: after that edge `ind_t0`=1 and `ind_t1`=`ind_t2`=0. The edge leaves `cnt_a`, `flag_e` and `flag_f` unchanged.
- R2: In idle with `start` low, the block stays idle and `cnt_a`, `flag_e` and `flag_f` hold their values.
- R3: In idle with `start` high, the next edge clears `cnt_a` to 0 and `flag_f` to 0 and moves the controller to counting (`ind_t1`=1).
- R4: Every edge taken in counting increments `cnt_a` by one.
- R5: Every edge taken in counting loads `flag_e` with bit 1 of `cnt_a` (the second bit, A2) as it was before that edge.
- R6: In counting, when bits 1 and 2 of `cnt_a` (A2 and A3) are both 1 before the edge, the next state is finished (`ind_t2`=1). Otherwise the block stays in counting. A run started from zero ends with `cnt_a`=7 and `flag_e`=1.
- R7: In finished, the next edge sets `flag_f` to 1 and returns to idle whatever `start` is. `flag_f` then holds until the next start clears it.
- R8: `start` has no effect while counting or finished. The count sequence and the exit point are the same whether it is high or low.
- R9: Exactly one of `ind_t0`, `ind_t1`, `ind_t2` is high on every cycle after reset.
- R10: If `start` is still high in the idle cycle that follows finished, a new run begins at once, with `cnt_a` and `flag_f` cleared again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, controller only |
| start | input | 1 | Start request, sampled in idle |
| cnt_a | output | 4 | Counter value, bit 0 is the least significant |
| flag_e | output | 1 | Status flip-flop, sampled counter bit |
| flag_f | output | 1 | Completion flag |
| ind_t0 | output | 1 | Idle indicator |
| ind_t1 | output | 1 | Counting indicator |
| ind_t2 | output | 1 | Finished indicator |

## Verification
Reset arriving in the middle of a count is the hardest case to reach from the ports, because it must leave a non-zero count and status flag untouched while the controller jumps to idle. The bench lets a run go for a few counting cycles and raises reset at a known count value. It then confirms that the count holds through reset and through the idle cycles after it. A second awkward case is a start request held high across a whole run. The controller must ignore it while counting and while finished, and act on it again only in the idle cycle after finished. The bench keeps start high from before the first edge until the restarted run has cleared the count.

// File: rtl/asm_cnt_pkg.sv
package asm_cnt_pkg;

    // Binary controller codes; the value 2'b10 is unused and decodes to no phase.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b11
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e state;
    } ctl_regs_t;

endpackage

// File: rtl/asm_seq_ctrl.sv
module asm_seq_ctrl
    import asm_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic exit_hit,
    output logic ind_t0,
    output logic ind_t1,
    output logic ind_t2,
    output logic op_clr,
    output logic op_inc,
    output logic op_setf
);

    ctl_regs_t ctl_d;
    ctl_regs_t ctl_q;

    // Phase decode from the present-state register.
    always_comb begin
        ind_t0 = (ctl_q.state == ST_IDLE);
        ind_t1 = (ctl_q.state == ST_RUN);
        ind_t2 = (ctl_q.state == ST_DONE);
    end

    // Datapath commands; reset suppresses them so the datapath holds.
    always_comb begin
        op_clr  = ind_t0 & start & ~rst;
        op_inc  = ind_t1 & ~rst;
        op_setf = ind_t2 & ~rst;
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: ctl_d.state = start    ? ST_RUN  : ST_IDLE;
            ST_RUN:  ctl_d.state = exit_hit ? ST_DONE : ST_RUN;
            ST_DONE: ctl_d.state = ST_IDLE;
            default: ctl_d.state = ST_IDLE;
        endcase
        if (rst) begin
            ctl_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/asm_cnt_dpath.sv
module asm_cnt_dpath #(
    parameter int CNT_W      = 4,
    parameter int SAMPLE_BIT = 1,
    parameter int EXIT_LO    = 1,
    parameter int EXIT_HI    = 2
) (
    input  logic             clk,
    input  logic             op_clr,
    input  logic             op_inc,
    input  logic             op_setf,
    output logic             exit_hit,
    output logic [CNT_W-1:0] cnt_a,
    output logic             flag_e,
    output logic             flag_f
);

    localparam logic [CNT_W-1:0] EXIT_MASK =
        CNT_W'((1 << EXIT_LO) | (1 << EXIT_HI));
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] a;
        logic             e;
        logic             f;
    } dp_regs_t;

    dp_regs_t dp_d;
    dp_regs_t dp_q;

    always_comb begin
        dp_d = dp_q;
        if (op_clr) begin
            dp_d.a = '0;
            dp_d.f = 1'b0;
        end
        if (op_inc) begin
            dp_d.a = dp_q.a + CNT_ONE;
            dp_d.e = dp_q.a[SAMPLE_BIT];
        end
        if (op_setf) begin
            dp_d.f = 1'b1;
        end
    end

    // No reset: the register contents are set up by a start request.
    always_ff @(posedge clk) begin
        dp_q <= dp_d;
    end

    always_comb begin
        exit_hit = ((dp_q.a & EXIT_MASK) == EXIT_MASK);
        cnt_a    = dp_q.a;
        flag_e   = dp_q.e;
        flag_f   = dp_q.f;
    end

endmodule

// File: rtl/asm_count_ctl.sv
module asm_count_ctl #(
    parameter int CNT_W      = 4,
    parameter int SAMPLE_BIT = 1,
    parameter int EXIT_LO    = 1,
    parameter int EXIT_HI    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] cnt_a,
    output logic             flag_e,
    output logic             flag_f,
    output logic             ind_t0,
    output logic             ind_t1,
    output logic             ind_t2
);

    logic exit_hit;
    logic op_clr;
    logic op_inc;
    logic op_setf;

    asm_seq_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .exit_hit (exit_hit),
        .ind_t0   (ind_t0),
        .ind_t1   (ind_t1),
        .ind_t2   (ind_t2),
        .op_clr   (op_clr),
        .op_inc   (op_inc),
        .op_setf  (op_setf)
    );

    asm_cnt_dpath #(
        .CNT_W      (CNT_W),
        .SAMPLE_BIT (SAMPLE_BIT),
        .EXIT_LO    (EXIT_LO),
        .EXIT_HI    (EXIT_HI)
    ) i_dpath (
        .clk      (clk),
        .op_clr   (op_clr),
        .op_inc   (op_inc),
        .op_setf  (op_setf),
        .exit_hit (exit_hit),
        .cnt_a    (cnt_a),
        .flag_e   (flag_e),
        .flag_f   (flag_f)
    );

endmodule

// File: rtl/asm_count_ctl_chk.sv
module asm_count_ctl_chk #(
    parameter int CNT_W      = 4,
    parameter int SAMPLE_BIT = 1,
    parameter int EXIT_LO    = 1,
    parameter int EXIT_HI    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] cnt_a,
    input logic             flag_e,
    input logic             flag_f,
    input logic             ind_t0,
    input logic             ind_t1,
    input logic             ind_t2
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (ind_t0 && !ind_t1 && !ind_t2)); // R1

    AST_RESET_KEEPS_DATA: assert property (@(posedge clk)
        rst |=> ($stable(cnt_a) && $stable(flag_e) && $stable(flag_f))); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ind_t0 && !start) |=> (ind_t0 && $stable(cnt_a) && $stable(flag_e) && $stable(flag_f))); // R2

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ind_t0 && start) |=> (ind_t1 && cnt_a == '0 && !flag_f)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        ind_t1 |=> (cnt_a == CNT_W'($past(cnt_a) + 1'b1))); // R4

    AST_E_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        ind_t1 |=> (flag_e == $past(cnt_a[SAMPLE_BIT]))); // R5

    AST_EXIT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (ind_t1 && cnt_a[EXIT_LO] && cnt_a[EXIT_HI]) |=> ind_t2); // R6

    AST_EXIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (ind_t1 && !(cnt_a[EXIT_LO] && cnt_a[EXIT_HI])) |=> ind_t1); // R6

    AST_DONE_RETURN: assert property (@(posedge clk) disable iff (rst)
        ind_t2 |=> (ind_t0 && flag_f)); // R7

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ($countones({ind_t0, ind_t1, ind_t2}) == 1)); // R9

endmodule

bind asm_count_ctl asm_count_ctl_chk #(
    .CNT_W      (CNT_W),
    .SAMPLE_BIT (SAMPLE_BIT),
    .EXIT_LO    (EXIT_LO),
    .EXIT_HI    (EXIT_HI)
) i_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cnt_a  (cnt_a),
    .flag_e (flag_e),
    .flag_f (flag_f),
    .ind_t0 (ind_t0),
    .ind_t1 (ind_t1),
    .ind_t2 (ind_t2)
);

// File: tb/test_asm_count_ctl.sv
`timescale 1ns/1ps
module test_asm_count_ctl;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] cnt_a;
    logic       flag_e;
    logic       flag_f;
    logic       ind_t0;
    logic       ind_t1;
    logic       ind_t2;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    asm_count_ctl i_asm_count_ctl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cnt_a  (cnt_a),
        .flag_e (flag_e),
        .flag_f (flag_f),
        .ind_t0 (ind_t0),
        .ind_t1 (ind_t1),
        .ind_t2 (ind_t2)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Phase vector {t0,t1,t2}: idle=4, counting=2, finished=1 (R9 one-hot).
    task automatic chk_phase(input string req, input int exp);
        chk(req, int'({ind_t0, ind_t1, ind_t2}), exp);
        chk("R9 one phase", $countones({ind_t0, ind_t1, ind_t2}), 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        start = 1'b0;
        tick();
        tick();
        rst = 1'b0;
        chk_phase("R1 reset idle", 4);
    endtask

    // Full run with start optionally held high throughout (R8).
    task automatic t_full_run(input bit hold_start);
        start = 1'b1;
        tick();
        chk_phase("R3 start to counting", 2);
        chk("R3 count cleared", int'(cnt_a), 0);
        chk("R3 flag_f cleared", int'(flag_f), 0);
        start = hold_start;
        for (int k = 0; k < 7; k++) begin
            tick();
            chk(hold_start ? "R8 count with start" : "R4 count step", int'(cnt_a), k + 1);
            chk("R5 flag_e sample", int'(flag_e), (k >> 1) & 1);
            chk_phase("R6 exit point", (k < 6) ? 2 : 1);
        end
        tick();
        chk_phase("R7 return idle", 4);
        chk("R7 flag_f set", int'(flag_f), 1);
        chk("R6 final count", int'(cnt_a), 7);
        chk("R6 final flag_e", int'(flag_e), 1);
    endtask

    task automatic t_idle_hold();
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk_phase("R2 idle stays", 4);
            chk("R2 count holds", int'(cnt_a), 7);
            chk("R2 flag_e holds", int'(flag_e), 1);
            chk("R2 flag_f holds", int'(flag_f), 1);
        end
    endtask

    // Start still high in the idle cycle after finished restarts (R10).
    task automatic t_restart();
        t_full_run(1'b1);
        tick();
        chk_phase("R10 restart counting", 2);
        chk("R10 count cleared", int'(cnt_a), 0);
        chk("R10 flag_f cleared", int'(flag_f), 0);
        start = 1'b0;
    endtask

    task automatic t_reset_mid();
        for (int k = 0; k < 3; k++) begin
            tick();
        end
        chk("R4 mid count", int'(cnt_a), 3);
        chk("R5 mid flag_e", int'(flag_e), 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk_phase("R1 mid reset idle", 4);
        chk("R1 count kept", int'(cnt_a), 3);
        chk("R1 flag_e kept", int'(flag_e), 1);
        chk("R1 flag_f kept", int'(flag_f), 0);
        tick();
        chk_phase("R2 idle after reset", 4);
        chk("R2 count after reset", int'(cnt_a), 3);
    endtask

    initial begin
        rst = 1'b1;
        start = 1'b0;
        #1;
        t_reset();
        t_full_run(1'b0);
        t_idle_hold();
        t_restart();
        t_reset_mid();
        t_full_run(1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule